// File: doc/BRIEF.md
# Selectable Output Rounding Stage

This stage sits at the tail of a video filter datapath. It takes a wide signed fixed-point accumulator result, reduces it to an unsigned output pixel of configurable width, and saturates it to the pixel range. The rounding rule is fixed when the block is elaborated. It can be plain truncation, round-to-nearest with exact halves moved away from zero, or round-to-nearest with exact halves resolved to the even neighbour.

The accumulator carries `FRAC_W` fraction bits below the pixel least significant bit. A result is produced one clock after each accepted input, together with a delayed valid strobe. Between valid inputs the output pixel keeps its last value. A filter result that undershoots below zero becomes 0, and one that overshoots the pixel range becomes the all-ones pixel.

Top module: `sel_round_stage`

## Requirements
- R1: `out_valid` equals `in_valid` from the previous rising clock edge, so every result appears exactly one clock after its input.
- R2: While `rst_n` is low, `out_valid` and `out_pix` are 0, whatever is driven on the inputs.
- R3: With `MODE` = 0 (truncation), the result is the accumulator divided by 2^FRAC_W and rounded toward negative infinity, so every bit below the output LSB is simply dropped.
- R4: With `MODE` = 1 (half away from zero) or `MODE` = 2 (half to even), a fractional remainder below one half rounds down and a remainder above one half rounds up.
- R5: With `MODE` = 1, a remainder of exactly one half rounds away from zero.
- R6: With `MODE` = 2, a remainder of exactly one half rounds to the neighbour whose LSB is 0.
- R7: A remainder counts as exactly one half only when the top dropped bit is 1 and every other dropped bit is 0. An input with all dropped bits zero passes through unchanged when it is in range.
- R8: Any result below zero after rounding is output as 0.
- R9: Any result above 2^PIX_W−1 after rounding is output as 2^PIX_W−1. This includes a value that only crosses the limit because of the round-up.
- R10: When `in_valid` is low on a rising edge, `out_pix` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accumulator value on `in_acc` is valid this cycle |
| in_acc | input | ACC_W | Signed two's-complement accumulator, `FRAC_W` fraction bits |
| out_valid | output | 1 | `out_pix` carries a new result |
| out_pix | output | PIX_W | Rounded and saturated unsigned pixel |

## Verification
Every result and every valid strobe is due on the first rising edge after the input is presented. No other register lies on the path. The bench drives each input on a falling edge and reads the outputs on the next falling edge, half a period after the register has updated. At that point it compares them against a behavioural model that has already been advanced by that one input. Three instances, one per rounding mode, see the same stimulus. The stimulus includes directed ties, near-ties, values just under and over the pixel range, negative undershoot and idle cycles, so the hold rule and each mode's tie handling are compared in the same cycle.

// File: rtl/sel_round_pkg.sv
package sel_round_pkg;

    // Rounding rule chosen at elaboration time.
    typedef enum logic [1:0] {
        RND_TRUNC     = 2'd0,  // drop fraction, toward negative infinity
        RND_HALF_AWAY = 2'd1,  // nearest, exact half away from zero
        RND_HALF_EVEN = 2'd2   // nearest, exact half to even neighbour
    } rnd_mode_e;

endpackage

// File: rtl/round_decide.sv
// Splits the accumulator into its floor integer part and the dropped fraction,
// then decides whether to add one LSB according to the selected rule.
module round_decide
    import sel_round_pkg::*;
#(
    parameter int        ACC_W  = 28,
    parameter int        FRAC_W = 10,
    parameter rnd_mode_e MODE   = RND_HALF_AWAY,
    localparam int       INT_W  = ACC_W - FRAC_W
) (
    input  logic [ACC_W-1:0] acc,
    output logic [INT_W:0]   rounded   // signed, one bit of headroom
);

    logic [INT_W-1:0] floor_part;
    logic             neg;
    logic             guard;
    logic             sticky;
    logic             bump;

    assign floor_part = acc[ACC_W-1:FRAC_W];
    assign neg        = acc[ACC_W-1];
    assign guard      = acc[FRAC_W-1];

    // Bits below the guard bit; absent when only one fraction bit exists.
    generate
        if (FRAC_W >= 2) begin : g_sticky
            assign sticky = |acc[FRAC_W-2:0];
        end else begin : g_no_sticky
            assign sticky = 1'b0;
        end
    endgenerate

    // Increment decision per rounding rule. Because floor_part is already
    // the floor, a negative tie "away from zero" means no increment.
    generate
        if (MODE == RND_TRUNC) begin : g_trunc
            assign bump = 1'b0;
        end else if (MODE == RND_HALF_AWAY) begin : g_away
            assign bump = guard & (sticky | ~neg);
        end else begin : g_even
            assign bump = guard & (sticky | floor_part[0]);
        end
    endgenerate

    always_comb begin
        rounded = {floor_part[INT_W-1], floor_part} + {{INT_W{1'b0}}, bump};
    end

endmodule

// File: rtl/pix_clamp.sv
// Saturates a signed rounded value into the unsigned pixel range.
module pix_clamp #(
    parameter int  IN_W  = 19,
    parameter int  PIX_W = 8,
    localparam int MAG_W = IN_W - 1
) (
    input  logic [IN_W-1:0]  val,    // signed two's complement
    output logic [PIX_W-1:0] pix
);

    logic             below;
    logic             above;
    logic [PIX_W-1:0] fit;

    assign below = val[IN_W-1];

    generate
        if (MAG_W > PIX_W) begin : g_wide
            assign above = |val[MAG_W-1:PIX_W];
            assign fit   = val[PIX_W-1:0];
        end else if (MAG_W == PIX_W) begin : g_equal
            assign above = 1'b0;
            assign fit   = val[PIX_W-1:0];
        end else begin : g_narrow
            assign above = 1'b0;
            assign fit   = {{(PIX_W-MAG_W){1'b0}}, val[MAG_W-1:0]};
        end
    endgenerate

    always_comb begin
        if (below) begin
            pix = '0;
        end else if (above) begin
            pix = '1;
        end else begin
            pix = fit;
        end
    end

endmodule

// File: rtl/sel_round_stage.sv
// One-clock rounding and saturation stage for filter accumulator results.
module sel_round_stage
    import sel_round_pkg::*;
#(
    parameter int        ACC_W  = 28,
    parameter int        FRAC_W = 10,
    parameter int        PIX_W  = 8,
    parameter rnd_mode_e MODE   = RND_HALF_AWAY
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [ACC_W-1:0] in_acc,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_pix
);

    localparam int INT_W = ACC_W - FRAC_W;
    localparam int RND_W = INT_W + 1;

    typedef struct packed {
        logic             vld;
        logic [PIX_W-1:0] pix;
    } stage_t;

    logic [RND_W-1:0] rounded;
    logic [PIX_W-1:0] sat_pix;
    stage_t           st_d;
    stage_t           st_q;

    round_decide #(
        .ACC_W  (ACC_W),
        .FRAC_W (FRAC_W),
        .MODE   (MODE)
    ) u_decide (
        .acc     (in_acc),
        .rounded (rounded)
    );

    pix_clamp #(
        .IN_W  (RND_W),
        .PIX_W (PIX_W)
    ) u_clamp (
        .val (rounded),
        .pix (sat_pix)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.pix = sat_pix;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_pix   = st_q.pix;

endmodule

// File: rtl/sel_round_stage_chk.sv
module sel_round_stage_chk #(
    parameter int ACC_W  = 28,
    parameter int FRAC_W = 10,
    parameter int PIX_W  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [ACC_W-1:0] in_acc,
    input logic             out_valid,
    input logic [PIX_W-1:0] out_pix
);

    localparam longint PIX_MAX = (longint'(1) <<< PIX_W) - 1;

    logic   neg_in;
    logic   frac_zero;
    longint int_mag;

    assign neg_in    = in_acc[ACC_W-1];
    assign frac_zero = (in_acc[FRAC_W-1:0] == '0);
    assign int_mag   = longint'(in_acc[ACC_W-2:FRAC_W]);

    // R1: valid strobe delayed by exactly one clock
    a_r1_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r1_idle_delay: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R10: pixel holds across idle cycles
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_pix));

    // R8: undershoot saturates to zero
    a_r8_low_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && neg_in) |=> (out_pix == '0));

    // R9: overshoot saturates to all ones
    a_r9_high_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !neg_in && (int_mag > PIX_MAX)) |=> (out_pix == '1));

    // R7: exact in-range values pass unchanged in every mode
    a_r7_exact_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !neg_in && frac_zero && (int_mag <= PIX_MAX))
        |=> (longint'(out_pix) == $past(int_mag)));

endmodule

bind sel_round_stage sel_round_stage_chk #(
    .ACC_W  (ACC_W),
    .FRAC_W (FRAC_W),
    .PIX_W  (PIX_W)
) u_chk (.*);

// File: tb/sel_round_stage_test.sv
module sel_round_stage_test;
    import sel_round_pkg::*;

    localparam int ACC_W  = 16;
    localparam int FRAC_W = 4;
    localparam int PIX_W  = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [ACC_W-1:0] in_acc = '0;
    logic             ov [3];
    logic [PIX_W-1:0] op [3];

    int      total = 0;
    int      bad = 0;
    int      cyc = 0;
    bit      done = 1'b0;
    string   tag = "R1";
    bit      exp_v [3];
    longint  exp_p [3];

    always #4 clk = ~clk;

    sel_round_stage #(.ACC_W(ACC_W), .FRAC_W(FRAC_W), .PIX_W(PIX_W), .MODE(RND_HALF_AWAY)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_acc(in_acc),
        .out_valid(ov[1]), .out_pix(op[1]));
    sel_round_stage #(.ACC_W(ACC_W), .FRAC_W(FRAC_W), .PIX_W(PIX_W), .MODE(RND_TRUNC)) uut_trunc (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_acc(in_acc),
        .out_valid(ov[0]), .out_pix(op[0]));
    sel_round_stage #(.ACC_W(ACC_W), .FRAC_W(FRAC_W), .PIX_W(PIX_W), .MODE(RND_HALF_EVEN)) uut_even (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_acc(in_acc),
        .out_valid(ov[2]), .out_pix(op[2]));

    // Behavioural reference: value = acc / 2^FRAC_W, mode 0/1/2.
    function automatic longint model(longint acc, int mode);
        longint one  = longint'(1) <<< FRAC_W;
        longint half = one / 2;
        longint fl   = acc >>> FRAC_W;
        longint rem  = acc - fl * one;
        longint r    = fl;
        longint top  = (longint'(1) <<< PIX_W) - 1;
        if (mode == 1) begin
            if (rem > half) r = fl + 1;
            else if (rem == half && acc >= 0) r = fl + 1;
        end else if (mode == 2) begin
            if (rem > half) r = fl + 1;
            else if (rem == half && (fl % 2 != 0)) r = fl + 1;
        end
        if (r < 0) r = 0;
        if (r > top) r = top;
        return r;
    endfunction

    task automatic chk(string t, string what, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", t, what, act, exp);
        end
    endtask

    // Compare outputs of the previous input, then present the next one.
    task automatic step(bit v, longint acc);
        @(negedge clk);
        for (int m = 0; m < 3; m++) begin
            chk(tag, $sformatf("mode%0d valid", m), longint'(ov[m]), longint'(exp_v[m]));
            chk(tag, $sformatf("mode%0d pix", m), longint'(op[m]), exp_p[m]);
        end
        for (int m = 0; m < 3; m++) begin
            exp_v[m] = v;
            if (v) exp_p[m] = model(acc, m);
        end
        in_valid = v;
        in_acc   = ACC_W'(acc);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
            finish_run();
        end
    end

    initial begin
        for (int m = 0; m < 3; m++) begin
            exp_v[m] = 1'b0;
            exp_p[m] = 0;
        end
        // R2: inputs active during reset must not reach the outputs
        in_valid = 1'b1;
        in_acc   = 16'd100;
        repeat (3) @(negedge clk);
        for (int m = 0; m < 3; m++) begin
            chk("R2", "reset valid", longint'(ov[m]), 0);
            chk("R2", "reset pix", longint'(op[m]), 0);
        end
        in_valid = 1'b0;
        rst_n    = 1'b1;

        tag = "R3"; step(1, 95);           // 5.9375: trunc 5, nearest 6
        tag = "R3"; step(1, 80 + 1);       // 5.0625
        tag = "R4"; step(1, 103);          // 6.4375 -> 6
        tag = "R4"; step(1, 105);          // 6.5625 -> 7
        tag = "R5"; step(1, 88);           // 5.5 away -> 6, even -> 6
        tag = "R6"; step(1, 104);          // 6.5 away -> 7, even -> 6
        tag = "R6"; step(1, 72);           // 4.5 even -> 4
        tag = "R7"; step(1, 96);           // exact 6
        tag = "R7"; step(1, 121);          // 7.5625, sticky set, not a tie
        tag = "R8"; step(1, -1);
        tag = "R8"; step(1, -8);           // -0.5 tie
        tag = "R8"; step(1, -32768);
        tag = "R9"; step(1, 254 * 16 + 8); // 254.5
        tag = "R9"; step(1, 255 * 16 + 8); // 255.5 rounds past the range
        tag = "R9"; step(1, 4095);
        tag = "R9"; step(1, 32767);
        tag = "R10"; step(1, 40);
        tag = "R10"; step(0, 200);         // idle: pixel must hold
        tag = "R10"; step(0, -5);
        tag = "R1"; step(1, 1234);
        tag = "R1"; step(0, 0);
        tag = "R1"; step(1, 0);

        // Mixed stream spanning undershoot, in-range and overshoot.
        tag = "R4";
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 5) != 0, longint'($urandom % 6000) - 600);
        end
        tag = "R1"; step(0, 0);
        step(0, 0);
        finish_run();
    end

endmodule